// File: doc/BRIEF.md
# Four-Way Least-Recently-Used Replacement Tracker

This block holds the replacement state of a single set in a four-way set-associative cache. The state is a 6-bit vector. Each bit records which way of one pair of ways was used less recently. Whenever the cache reports a hit or a fill on a way, the tracker marks that way as the most recently used. The tracker always presents the least recently used way as the victim that a later miss should replace.

Software can overwrite the whole vector and read it back. The two resets behave differently. A power-on reset clears the vector. A manual reset keeps it as it is. A cache built from this block places one instance per set, or an array of the vector indexed by set address, next to its tag store.

Top module: `lru4_order_tracker`

## Requirements
- R1: While `por_rst` is sampled high at a rising clock edge, the state becomes 6'b000000 at that edge. This has priority over every other input. From that state the victim is way 3.
- R2: While `man_rst` is sampled high and `por_rst` is low, the state keeps its value at that edge. Any access or software write presented in the same cycle is ignored.
- R3: The pair bits are: bit 5 = ways (0,1), bit 4 = (0,2), bit 3 = (0,3), bit 2 = (1,2), bit 1 = (1,3), bit 0 = (2,3). A 1 means the lower-numbered way of the pair is the older one. `victim` is combinational from the state and gives the way that is older than the other three. Way 0 is chosen when bits 5, 4 and 3 are all 1. Way 1 is chosen when bit 5 is 0 and bits 2 and 1 are 1. Way 2 is chosen when bits 4 and 2 are 0 and bit 0 is 1. Way 3 is chosen when bits 3, 1 and 0 are 0.
- R4: An access (`acc_vld` high) to way w is applied at the next edge. It clears every bit of a pair (w,x) with x > w and sets every bit of a pair (x,w) with x < w. All other bits are left unchanged.
- R5: After accesses to all four ways in any order, `victim` names the way among those four accesses that was accessed first.
- R6: The cycle after an access that has no competing write or reset, `victim` differs from the way that was accessed.
- R7: With `sw_we` high, `sw_wdata` is loaded into the state at the next edge and appears on `state_q`. The 24 legal patterns are exactly the vectors of a strict ordering of the four ways.
- R8: When `sw_we` and `acc_vld` are both high in the same cycle, the written value is stored and the access is dropped.
- R9: Starting from power-on reset, with only legal software writes, every state the block reaches is one of the 24 legal patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| por_rst | input | 1 | Synchronous active-high power-on reset; clears the state |
| man_rst | input | 1 | Synchronous active-high manual reset; holds the state |
| acc_vld | input | 1 | A hit or fill occurred on `acc_way` this cycle |
| acc_way | input | 2 | Way index of the access |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 6 | Vector to load on a software write |
| state_q | output | 6 | Registered state, used for read-back |
| victim | output | 2 | Way to replace on a miss |

## Verification
The hardest part to reach from the ports is full coverage of the 24 legal orderings, each reached through accesses as well as through writes. A random access stream alone visits them unevenly. The bench therefore loads every legal pattern through the write port, checking the read-back and the victim for each. It then drives every one of the 24 orders of four distinct accesses from power-on reset, followed by a long pseudo-random access stream. Collisions between a write and an access, and between a manual reset and both, are set up in single cycles so that the dropped operation would be visible on `state_q`.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
  localparam int NWAY  = 4;
  localparam int WAY_W = $clog2(NWAY);
  localparam int ORD_W = NWAY * (NWAY - 1) / 2;

  typedef logic [ORD_W-1:0] ord_t;
  typedef logic [WAY_W-1:0] way_t;

  // Bit position of pair (lo,hi), lo<hi; pairs ordered lexicographically from the MSB down.
  function automatic int pair_bit(int lo, int hi);
    int k;
    k = 0;
    for (int a = 0; a < lo; a++) k += NWAY - 1 - a;
    k += hi - lo - 1;
    return ORD_W - 1 - k;
  endfunction

  // True when way i was used less recently than way j.
  function automatic logic is_older(ord_t v, int i, int j);
    if (i < j) return v[pair_bit(i, j)];
    return !v[pair_bit(j, i)];
  endfunction

  // True when way w is older than every other way.
  function automatic logic oldest_of_all(ord_t v, int w);
    logic r;
    r = 1'b1;
    for (int x = 0; x < NWAY; x++)
      if (x != w && !is_older(v, w, x)) r = 1'b0;
    return r;
  endfunction

  // A vector is legal when the relation it encodes is transitive.
  function automatic logic order_legal(ord_t v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NWAY; i++)
      for (int j = 0; j < NWAY; j++)
        for (int k = 0; k < NWAY; k++)
          if (i != j && j != k && i != k)
            if (is_older(v, i, j) && is_older(v, j, k) && !is_older(v, i, k)) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/lru4_touch.sv
module lru4_touch
  import lru4_pkg::*;
(
  input  ord_t cur,
  input  logic acc_vld,
  input  way_t acc_way,
  output ord_t nxt
);
  for (genvar lo = 0; lo < NWAY; lo++) begin : g_lo
    for (genvar hi = lo + 1; hi < NWAY; hi++) begin : g_hi
      localparam int B = pair_bit(lo, hi);
      always_comb begin
        if (acc_vld && acc_way == way_t'(lo))      nxt[B] = 1'b0; // lo becomes newer
        else if (acc_vld && acc_way == way_t'(hi)) nxt[B] = 1'b1; // lo becomes older
        else                                       nxt[B] = cur[B];
      end
    end
  end
endmodule

// File: rtl/lru4_victim.sv
module lru4_victim
  import lru4_pkg::*;
(
  input  logic clk,
  input  logic por_rst,
  input  ord_t cur,
  output way_t victim
);
  logic [NWAY-1:0] is_oldest;

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    assign is_oldest[w] = oldest_of_all(cur, w);
  end

  always_comb begin
    victim = '0;
    for (int w = NWAY - 1; w >= 0; w--)
      if (is_oldest[w]) victim = way_t'(w);
  end

  // R3: a legal vector names exactly one oldest way
  a_r3_single_oldest: assert property (@(posedge clk) disable iff (por_rst)
    $onehot(is_oldest));
endmodule

// File: rtl/lru4_state_reg.sv
module lru4_state_reg
  import lru4_pkg::*;
(
  input  logic clk,
  input  logic por_rst,
  input  logic man_rst,
  input  logic sw_we,
  input  ord_t sw_wdata,
  input  ord_t upd,
  output ord_t state_q
);
  always_ff @(posedge clk) begin
    if (por_rst)       state_q <= '0;
    else if (!man_rst) state_q <= sw_we ? sw_wdata : upd;
  end

  a_r1_por_clears: assert property (@(posedge clk)
    por_rst |=> state_q == '0);
  a_r2_manual_holds: assert property (@(posedge clk) disable iff (por_rst)
    man_rst |=> $stable(state_q));
  a_r8_write_wins: assert property (@(posedge clk) disable iff (por_rst)
    (sw_we && !man_rst) |=> state_q == $past(sw_wdata));
endmodule

// File: rtl/lru4_order_tracker.sv
module lru4_order_tracker
  import lru4_pkg::*;
(
  input  logic       clk,
  input  logic       por_rst,
  input  logic       man_rst,
  input  logic       acc_vld,
  input  logic [1:0] acc_way,
  input  logic       sw_we,
  input  logic [5:0] sw_wdata,
  output logic [5:0] state_q,
  output logic [1:0] victim
);
  ord_t cur, upd;

  lru4_touch u_touch (
    .cur(cur), .acc_vld(acc_vld), .acc_way(acc_way), .nxt(upd)
  );

  lru4_state_reg u_state (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .sw_we(sw_we),
    .sw_wdata(sw_wdata), .upd(upd), .state_q(cur)
  );

  lru4_victim u_victim (
    .clk(clk), .por_rst(por_rst), .cur(cur), .victim(victim)
  );

  assign state_q = cur;

  // R6: the way just accessed is the most recent, never the victim
  a_r6_mru_not_victim: assert property (@(posedge clk) disable iff (por_rst)
    (acc_vld && !sw_we && !man_rst) |=> victim != $past(acc_way));
  // R9: state remains a legal ordering
  a_r9_legal_state: assert property (@(posedge clk) disable iff (por_rst)
    order_legal(state_q));
endmodule

// File: tb/test_lru4_order_tracker.sv
module test_lru4_order_tracker;
  localparam time PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_rst, man_rst, acc_vld, sw_we;
  logic [1:0] acc_way;
  logic [5:0] sw_wdata;
  logic [5:0] state_q;
  logic [1:0] victim;

  int n_chk = 0, n_bad = 0;
  int ord[4];               // model: ord[0] is the oldest way
  logic [63:0] legal_mask = '0;

  always #(PERIOD/2) clk = ~clk;

  lru4_order_tracker i_lru4_order_tracker (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .acc_vld(acc_vld),
    .acc_way(acc_way), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .state_q(state_q), .victim(victim)
  );

  function automatic int tb_bit(int lo, int hi);
    case ({lo[1:0], hi[1:0]})
      4'b0001: return 5;
      4'b0010: return 4;
      4'b0011: return 3;
      4'b0110: return 2;
      4'b0111: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [5:0] model_vec();
    logic [5:0] v;
    int pos[4];
    v = '0;
    for (int p = 0; p < 4; p++) pos[ord[p]] = p;
    for (int lo = 0; lo < 4; lo++)
      for (int hi = lo + 1; hi < 4; hi++)
        v[tb_bit(lo, hi)] = (pos[lo] < pos[hi]);
    return v;
  endfunction

  // Rebuild the model order from a legal vector (rank = number of ways older than it).
  function automatic void model_from_vec(logic [5:0] v);
    for (int w = 0; w < 4; w++) begin
      int r;
      r = 0;
      for (int x = 0; x < 4; x++)
        if (x != w) begin
          if (x < w && v[tb_bit(x, w)])  r++;
          if (x > w && !v[tb_bit(w, x)]) r++;
        end
      ord[r] = w;
    end
  endfunction

  function automatic void touch(int w);
    int p;
    p = 0;
    for (int i = 0; i < 4; i++) if (ord[i] == w) p = i;
    for (int i = p; i < 3; i++) ord[i] = ord[i+1];
    ord[3] = w;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    acc_vld = 0; sw_we = 0; man_rst = 0; por_rst = 0; acc_way = '0; sw_wdata = '0;
  endtask

  task automatic do_por();
    idle(); por_rst = 1; cyc(); cyc(); por_rst = 0;
    ord = '{3, 2, 1, 0};
  endtask

  task automatic t_por();
    idle(); sw_we = 1; sw_wdata = 6'b111111; cyc();
    por_rst = 1; man_rst = 1; acc_vld = 1; acc_way = 2'd2; cyc();
    chk("R1 state", state_q, 0);
    chk("R1 victim", victim, 3);
    do_por();
  endtask

  task automatic t_table();
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              logic [5:0] v;
              ord = '{a, b, c, d};
              v = model_vec();
              legal_mask[v] = 1'b1;
              idle(); sw_we = 1; sw_wdata = v; cyc(); idle();
              chk("R7 readback", state_q, v);
              chk("R3 victim", victim, a);
            end
    chk("R7 legal count", $countones(legal_mask), 24);
    // literal table samples for R3
    idle(); sw_we = 1; sw_wdata = 6'b110100; cyc(); chk("R3 way3", victim, 3);
    sw_wdata = 6'b101011; cyc(); chk("R3 way2", victim, 2);
    sw_wdata = 6'b011111; cyc(); chk("R3 way1", victim, 1);
    sw_wdata = 6'b111000; cyc(); chk("R3 way0", victim, 0);
    idle();
  endtask

  task automatic t_fill_orders();
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              int seq[4];
              seq = '{a, b, c, d};
              do_por();
              foreach (seq[i]) begin
                acc_vld = 1; acc_way = seq[i][1:0]; cyc(); idle();
                touch(seq[i]);
                chk("R4 state", state_q, model_vec());
                chk("R6 victim not mru", int'(victim == seq[i][1:0]), 0);
              end
              chk("R5 earliest", victim, a);
            end
  endtask

  task automatic t_random();
    do_por();
    for (int n = 0; n < 400; n++) begin
      int w;
      w = $urandom_range(0, 3);
      if ($urandom_range(0, 15) == 0) begin
        logic [5:0] v;
        for (int k = 0; k < 4; k++) touch($urandom_range(0, 3));
        v = model_vec();
        sw_we = 1; sw_wdata = v;
      end else begin
        acc_vld = 1; acc_way = w[1:0];
        touch(w);
      end
      cyc(); idle();
      chk("R4 random state", state_q, model_vec());
      chk("R9 legal", int'(legal_mask[state_q]), 1);
      chk("R3 random victim", victim, ord[0]);
    end
  endtask

  task automatic t_collision();
    do_por();
    sw_we = 1; sw_wdata = 6'b011110; acc_vld = 1; acc_way = 2'd1; cyc(); idle();
    chk("R8 write wins", state_q, 6'b011110);
    chk("R8 victim", victim, 1);
  endtask

  task automatic t_manual();
    do_por();
    sw_we = 1; sw_wdata = 6'b001011; cyc(); idle();
    man_rst = 1; acc_vld = 1; acc_way = 2'd2; cyc();
    chk("R2 access ignored", state_q, 6'b001011);
    sw_we = 1; sw_wdata = 6'b111111; cyc();
    chk("R2 write ignored", state_q, 6'b001011);
    idle(); cyc();
    chk("R2 kept after release", state_q, 6'b001011);
    chk("R2 victim", victim, 2);
  endtask

  initial begin
    idle(); por_rst = 1;
    cyc(); cyc();
    chk("R1 reset state", state_q, 0);
    chk("R1 reset victim", victim, 3);
    t_por();
    t_table();
    t_fill_orders();
    t_random();
    t_collision();
    t_manual();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule